// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm

This block keeps a free-running 48-bit count of ticks from a 32.768 kHz time base and presents it to software through a small 16-bit register bus. The clock is supplied to the block as a one-cycle enable, `tick_en`. Whole seconds are the count divided by 32768, so the seconds value sits at bit 15 and above. The value is visible as three 16-bit words. Software may write any word at any time.

A 48-bit alarm value is held in three further words. When a tick brings the counter to exactly that value, a sticky status bit is set. Software clears the bit by writing a one to it. The interrupt line is the status bit gated by a software enable bit.

The bus is a single-cycle write strobe with a combinational read path. Because the counter keeps running between word reads, a multi-word read may tear. Software handles this by reading twice and comparing the results.

Top module: `elapsed_alarm_top`

## Requirements
- R1: After reset the counter, the alarm value, the status bit and the enable bit are all zero, and `irq` is low.
- R2: In each cycle with `tick_en` high and no counter-word write, the 48-bit counter advances by one. In cycles with `tick_en` low and no counter-word write, the counter holds.
- R3: The counter reads as three words: offset 0x00 holds bits 15:0, offset 0x02 holds bits 31:16 and offset 0x04 holds bits 47:32. Whole seconds are the count shifted right by 15, so bit 15 of the word at 0x00 is the seconds LSB.
- R4: A write to a counter word loads that word at the next edge. The load overrides the tick for that word only. The other words take the incremented value, including any carry out of the old contents of the written word.
- R5: The alarm value uses the same three-word layout at offsets 0x08 (bits 15:0), 0x0A (bits 31:16) and 0x0C (bits 47:32), and it reads back what was written.
- R6: Bit 0 of the status word at offset 0x1E is set at the edge where a tick, with no counter-word write in that cycle, makes the counter equal to the alarm value. Loading the counter with the alarm value through a write does not set it.
- R7: The status bit stays set until a write to 0x1E with bit 0 equal to one. A write with bit 0 equal to zero has no effect. If a clear and a new match fall in the same cycle, the bit stays set.
- R8: Bit 0 of the word at offset 0x10 is the interrupt enable. `irq` is high exactly when the status bit and the enable bit are both one.
- R9: When the counter holds all ones, a tick takes it to zero. An alarm value of zero matches on that wrap.
- R10: Every other offset, and every bit of 0x10 and 0x1E except bit 0, reads as zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse from the 32.768 kHz time base |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Alarm interrupt: status bit AND enable bit |

## Verification
The hardest situation to reach is a write-one-to-clear landing in the same cycle as the matching tick. A close second is a match at the 48-bit wrap, since a running counter would need 2^48 ticks to get there. The bench reaches both by preloading the counter, one word at a time, to a few counts below the alarm value. It then issues single ticks, so it knows the exact cycle of the match and can place the clear write on that same edge. A long mixed stretch of random ticks, word writes and reads then keeps the alarm value close to the running count, so matches and overrides also occur unplanned.

// File: rtl/elapsed_alarm_pkg.sv
package elapsed_alarm_pkg;
   // Register map, byte offsets
   localparam int unsigned CNT_BASE  = 'h00;
   localparam int unsigned CMP_BASE  = 'h08;
   localparam int unsigned EN_OFF    = 'h10;
   localparam int unsigned STAT_OFF  = 'h1E;
   // At most four 16-bit words fit before the alarm block
   localparam int unsigned MAX_WORDS = 4;
endpackage

// File: rtl/ea_counter.sv
module ea_counter #(
   parameter int unsigned CNT_W  = 48,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned NW    = CNT_W / WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [NW-1:0]     wr_word_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  cnt_inc_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc   = cnt_q + CNT_W'(1);
   assign cnt_o     = cnt_q;
   assign cnt_inc_o = cnt_inc;

   for (genvar g = 0; g < NW; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q[g*WORD_W +: WORD_W] <= '0;
         else if (wr_word_i[g])
            cnt_q[g*WORD_W +: WORD_W] <= wdata_i;
         else if (tick_i)
            cnt_q[g*WORD_W +: WORD_W] <= cnt_inc[g*WORD_W +: WORD_W];
      end

      AST_WORD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         wr_word_i[g] |=> cnt_q[g*WORD_W +: WORD_W] == $past(wdata_i)); // R4
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && wr_word_i == '0) |=> $stable(cnt_q)); // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && wr_word_i == '0) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2
endmodule

// File: rtl/ea_compare.sv
module ea_compare #(
   parameter int unsigned CNT_W  = 48,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned NW    = CNT_W / WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NW-1:0]     wr_word_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              tick_i,
   input  logic              cnt_wr_i,
   input  logic [CNT_W-1:0]  cnt_inc_i,
   output logic [CNT_W-1:0]  cmp_o,
   output logic              match_o
);
   logic [CNT_W-1:0] cmp_q;

   for (genvar g = 0; g < NW; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cmp_q[g*WORD_W +: WORD_W] <= '0;
         else if (wr_word_i[g])
            cmp_q[g*WORD_W +: WORD_W] <= wdata_i;
      end
   end

   assign cmp_o   = cmp_q;
   // Match on the value the counter is about to take from a tick
   assign match_o = tick_i && !cnt_wr_i && (cnt_inc_i == cmp_q);

   AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_word_i == '0) |=> $stable(cmp_q)); // R5
endmodule

// File: rtl/ea_status.sv
module ea_status #(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic en_wr_i,
   input  logic en_d_i,
   output logic st_o,
   output logic en_o,
   output logic irq_o
);
   logic st_q;
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= 1'b0;
         en_q <= 1'b0;
      end else begin
         st_q <= (st_q && !clr_i) || set_i;
         if (en_wr_i)
            en_q <= en_d_i;
      end
   end

   assign st_o = st_q;
   assign en_o = en_q;

   if (IRQ_REGISTERED) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= st_q && en_q;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = st_q && en_q;
   end

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> st_q); // R6
   AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q && !clr_i) |=> st_q); // R7
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q && clr_i && !set_i) |=> !st_q); // R7
endmodule

// File: rtl/elapsed_alarm_top.sv
module elapsed_alarm_top
   import elapsed_alarm_pkg::*;
#(
   parameter int unsigned CNT_W          = 48,
   parameter int unsigned WORD_W         = 16,
   parameter int unsigned ADDR_W         = 5,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int unsigned NW = CNT_W / WORD_W;

   if (CNT_W % WORD_W != 0) begin : g_bad_width
      $error("CNT_W must be a multiple of WORD_W");
   end
   if (NW > MAX_WORDS || NW < 1) begin : g_bad_words
      $error("word count out of range");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W too small for register map");
   end

   logic [NW-1:0]    wr_cnt;
   logic [NW-1:0]    wr_cmp;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cmp;
   logic             match;
   logic             st;
   logic             en;
   logic             wr_en;
   logic             wr_clr;

   for (genvar g = 0; g < NW; g++) begin : g_dec
      assign wr_cnt[g] = reg_wr && (reg_addr == ADDR_W'(CNT_BASE + 2*g));
      assign wr_cmp[g] = reg_wr && (reg_addr == ADDR_W'(CMP_BASE + 2*g));
   end
   assign wr_en  = reg_wr && (reg_addr == ADDR_W'(EN_OFF));
   assign wr_clr = reg_wr && (reg_addr == ADDR_W'(STAT_OFF)) && reg_wdata[0];

   ea_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_en),
      .wr_word_i (wr_cnt),
      .wdata_i   (reg_wdata),
      .cnt_o     (cnt),
      .cnt_inc_o (cnt_inc)
   );

   ea_compare #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_word_i (wr_cmp),
      .wdata_i   (reg_wdata),
      .tick_i    (tick_en),
      .cnt_wr_i  (|wr_cnt),
      .cnt_inc_i (cnt_inc),
      .cmp_o     (cmp),
      .match_o   (match)
   );

   ea_status #(.IRQ_REGISTERED(IRQ_REGISTERED)) u_st (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (match),
      .clr_i   (wr_clr),
      .en_wr_i (wr_en),
      .en_d_i  (reg_wdata[0]),
      .st_o    (st),
      .en_o    (en),
      .irq_o   (irq)
   );

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < int'(NW); i++) begin
         if (reg_addr == ADDR_W'(CNT_BASE + 2*i)) reg_rdata = cnt[i*WORD_W +: WORD_W];
         if (reg_addr == ADDR_W'(CMP_BASE + 2*i)) reg_rdata = cmp[i*WORD_W +: WORD_W];
      end
      if (reg_addr == ADDR_W'(EN_OFF))   reg_rdata = WORD_W'(en);
      if (reg_addr == ADDR_W'(STAT_OFF)) reg_rdata = WORD_W'(st);
   end

   AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !IRQ_REGISTERED) |-> !irq); // R8
endmodule

// File: tb/elapsed_alarm_top_tb_top.sv
`timescale 1ns/1ps
module elapsed_alarm_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq;

   always #2.5 clk = ~clk;

   elapsed_alarm_top dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   localparam longint unsigned MASK = 64'h0000_FFFF_FFFF_FFFF;
   longint unsigned m_cnt = 0, m_cmp = 0;
   bit m_st = 0, m_en = 0;
   int compared = 0, mismatched = 0;
   bit finished = 0;

   function automatic longint unsigned put_word(longint unsigned v, int k, logic [15:0] d);
      longint unsigned cleared;
      cleared = v & ~(64'hFFFF << (16*k));
      return cleared | (longint'(d) << (16*k));
   endfunction

   function automatic logic [15:0] model_read(logic [4:0] a);
      case (a)
         5'h00: return 16'(m_cnt);
         5'h02: return 16'(m_cnt >> 16);
         5'h04: return 16'(m_cnt >> 32);
         5'h08: return 16'(m_cmp);
         5'h0A: return 16'(m_cmp >> 16);
         5'h0C: return 16'(m_cmp >> 32);
         5'h10: return {15'd0, m_en};
         5'h1E: return {15'd0, m_st};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic model_update(bit wr, logic [4:0] a, logic [15:0] d, bit tk);
      longint unsigned nc, up;
      bit cw, hit, clr;
      up  = (m_cnt + 1) & MASK;
      nc  = tk ? up : m_cnt;
      cw  = wr && (a == 5'h00 || a == 5'h02 || a == 5'h04);
      hit = tk && !cw && (up == m_cmp);
      clr = wr && a == 5'h1E && d[0];
      if (cw) nc = put_word(nc, int'(a) / 2, d);
      if (wr && (a == 5'h08 || a == 5'h0A || a == 5'h0C))
         m_cmp = put_word(m_cmp, (int'(a) - 8) / 2, d);
      if (wr && a == 5'h10) m_en = d[0];
      m_st  = (m_st && !clr) || hit;
      m_cnt = nc;
   endtask

   // One bus cycle: drive, compare outputs against the model, then clock both
   task automatic step(bit wr, logic [4:0] a, logic [15:0] d, bit tk, string tag);
      logic [15:0] exp_rd;
      bit exp_irq;
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d; tick_en = tk;
      #1;
      exp_rd  = model_read(a);
      exp_irq = m_st && m_en;
      compared++;
      if (reg_rdata !== exp_rd || irq !== exp_irq) begin
         mismatched++;
         $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp=%b", tag, a, reg_rdata, exp_rd, irq, exp_irq);
      end
      @(posedge clk);
      model_update(wr, a, d, tk);
   endtask

   task automatic wr_reg(logic [4:0] a, logic [15:0] d, string tag);
      step(1'b1, a, d, 1'b0, tag);
   endtask

   task automatic load_cnt(longint unsigned v, string tag);
      wr_reg(5'h00, 16'(v), tag);
      wr_reg(5'h02, 16'(v >> 16), tag);
      wr_reg(5'h04, 16'(v >> 32), tag);
   endtask

   task automatic load_cmp(longint unsigned v, string tag);
      wr_reg(5'h08, 16'(v), tag);
      wr_reg(5'h0A, 16'(v >> 16), tag);
      wr_reg(5'h0C, 16'(v >> 32), tag);
   endtask

   task automatic read_all(string tag);
      step(0, 5'h00, 0, 0, tag); step(0, 5'h02, 0, 0, tag); step(0, 5'h04, 0, 0, tag);
      step(0, 5'h08, 0, 0, tag); step(0, 5'h0A, 0, 0, tag); step(0, 5'h0C, 0, 0, tag);
      step(0, 5'h10, 0, 0, tag); step(0, 5'h1E, 0, 0, tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [4:0] addrs [9] = '{5'h00, 5'h02, 5'h04, 5'h08, 5'h0A, 5'h0C, 5'h10, 5'h1E, 5'h06};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      read_all("R1 reset state");

      for (int i = 0; i < 40; i++) step(0, 5'h00, 0, 1'(i % 3 != 1), "R2 counting");
      for (int i = 0; i < 5; i++)  step(0, 5'h00, 0, 0, "R2 hold");

      load_cnt(64'h0001_2345_8000, "R3 word layout");
      read_all("R3 word layout");
      load_cnt(64'h0000_0000_7FFF, "R3 seconds bit");
      step(0, 5'h00, 0, 1, "R3 seconds bit");
      step(0, 5'h00, 0, 0, "R3 seconds bit");

      load_cnt(64'h0000_1234_FFFF, "R4 override");
      step(1, 5'h02, 16'h5555, 1, "R4 override carry");
      read_all("R4 override carry");
      step(1, 5'h00, 16'hABCD, 1, "R4 override low");
      read_all("R4 override low");

      load_cmp(64'h0000_0001_0010, "R5 alarm value");
      read_all("R5 alarm value");

      load_cnt(64'h0000_0001_000D, "R6 match");
      for (int i = 0; i < 4; i++) step(0, 5'h1E, 0, 1, "R6 match");
      step(1, 5'h1E, 16'h0000, 0, "R7 write zero");
      step(0, 5'h1E, 0, 0, "R7 write zero");
      step(1, 5'h1E, 16'h0001, 0, "R7 clear");
      step(0, 5'h1E, 0, 0, "R7 clear");
      wr_reg(5'h00, 16'h0010, "R6 load equal no set");
      step(0, 5'h1E, 0, 0, "R6 load equal no set");

      load_cnt(64'h0000_0001_000E, "R7 clear vs match");
      step(0, 5'h1E, 0, 1, "R7 clear vs match");
      step(1, 5'h1E, 16'h0001, 1, "R7 clear vs match");
      step(0, 5'h1E, 0, 0, "R7 clear vs match");

      wr_reg(5'h10, 16'h0001, "R8 enable");
      step(0, 5'h10, 0, 0, "R8 enable");
      wr_reg(5'h1E, 16'h0001, "R8 irq drops");
      step(0, 5'h1E, 0, 0, "R8 irq drops");

      load_cmp(64'h0, "R9 wrap");
      load_cnt(MASK, "R9 wrap");
      step(0, 5'h00, 0, 1, "R9 wrap");
      read_all("R9 wrap");

      for (int i = 0; i < 16; i++) begin
         logic [4:0] a;
         a = 5'(2 * i);
         if (!(a inside {5'h00, 5'h02, 5'h04, 5'h08, 5'h0A, 5'h0C, 5'h10, 5'h1E})) begin
            wr_reg(a, 16'hFFFF, "R10 reserved");
            step(0, a, 0, 0, "R10 reserved");
         end
      end
      wr_reg(5'h07, 16'hFFFF, "R10 odd offset");
      read_all("R10 state unchanged");

      for (int i = 0; i < 3000; i++) begin
         bit wr;
         logic [4:0] a;
         logic [15:0] d;
         wr = ($urandom % 10) < 3;
         a  = addrs[$urandom % 9];
         d  = 16'($urandom);
         if (a == 5'h00 && wr) d = 16'(m_cmp) - 16'($urandom % 4);
         if (a == 5'h08 && wr) d = 16'(m_cnt) + 16'($urandom % 6);
         step(wr, a, d, 1'($urandom % 2), "R4 mixed traffic");
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule